// File: doc/BRIEF.md
# Automatic frequency offset adjuster

This block trims a synthesizer's frequency control word to cancel a measured transmit-to-receive carrier error. A signed offset estimate arrives with a valid flag. The block clips the estimate to a programmable symmetric window and holds the clipped value in a register. It adds that value to a 12-bit base word and clamps the sum to the usable word span. The result drives the synthesizer.

An enable bit switches the function on or off. When it is off, the base word passes straight through and all stored offsets are cleared. When it is on, a mode bit selects one of two behaviours. In automatic mode, every valid estimate is applied at once. In manual mode, estimates are only latched, and a rising edge on a strobe input applies the latched estimate. Offset estimation and the synthesizer itself are outside this block.

Top module: `freq_trim`

## Requirements
- R1: While `enable_i` is 0, `word_o` equals `base_word_i` combinationally, with no clamping, including values outside the span.
- R2: While `enable_i` is 1, `word_o` equals the unsigned `base_word_i` plus the signed applied offset, clamped to the range 96 to 3903. The sum never wraps.
- R3: `range_sel_i` sets the window used when an offset is applied: 0 gives ±3, 1 gives ±7, 2 gives ±15 and 3 gives no limit. An estimate beyond the window saturates at the bound of matching sign. `ofs_i` is 6-bit two's complement.
- R4: In automatic mode (`auto_mode_i` = 1), an estimate with `ofs_valid_i` = 1 becomes the applied offset at that clock edge, so `word_o` reflects it one clock later. Without a valid estimate, the applied offset holds.
- R5: In manual mode (`auto_mode_i` = 0), a valid estimate is stored as pending and does not change `word_o`.
- R6: In manual mode, a rising edge on `strobe_i` applies the pending estimate, with limiting, at that clock edge. If a valid estimate arrives in the same cycle as the edge, that estimate is the one applied.
- R7: In manual mode, holding `strobe_i` high applies nothing further. Estimates that arrive while it is held stay pending.
- R8: While `enable_i` is 0, the applied and pending offsets are cleared to 0. After re-enabling, `word_o` equals the clamped base word until a new offset is applied.
- R9: The window in force is the one present when the offset is applied. A later change of `range_sel_i` does not alter the applied offset.
- R10: Reset (`rst_ni` low) clears the applied offset, the pending offset and the strobe history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Turns the correction on |
| auto_mode_i | input | 1 | 1 selects automatic mode, 0 selects manual (strobe) mode |
| range_sel_i | input | 2 | Offset window select |
| strobe_i | input | 1 | Manual apply strobe; acts on its rising edge |
| base_word_i | input | 12 | Uncorrected frequency control word |
| ofs_i | input | 6 | Signed offset estimate |
| ofs_valid_i | input | 1 | Marks `ofs_i` as a new estimate |
| word_o | output | 12 | Corrected frequency control word |

## Verification
The bench targets the ends of each window: +31 and -16 against ±15, and -32 with no limit. A limiter that compares unsigned, or that drops the sign on the lower bound, would let the raw value through or flip its polarity. It also pushes sums past both ends of the word span and feeds an out-of-span base. A design that wraps instead of clamping would return a word near the opposite end of the span. In manual mode, it holds the strobe high while new estimates arrive, applies at an edge that coincides with a valid estimate, changes the window after application, and toggles the enable. A level-sensitive strobe, a stale pending value, or an enable that fails to clear the pending offset each shows up as a wrong word at the next strobe.

// File: rtl/freq_trim_pkg.sv
package freq_trim_pkg;
  typedef enum logic [1:0] {
    WIN_3    = 2'd0,
    WIN_7    = 2'd1,
    WIN_15   = 2'd2,
    WIN_FULL = 2'd3
  } win_e;
  localparam int N_WIN = 4;
endpackage

// File: rtl/offset_limiter.sv
module offset_limiter import freq_trim_pkg::*; #(
  parameter int OFS_W = 6
) (
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [1:0]       range_sel_i,
  output logic [OFS_W-1:0] lim_o
);
  localparam int LW = OFS_W + 1;

  logic signed [LW-1:0] bound [N_WIN];
  logic signed [LW-1:0] val, mag, res;

  // window k is +/-(2^(k+2)-1); the last one covers the whole estimate range
  for (genvar k = 0; k < N_WIN; k++) begin : g_bound
    if (k == N_WIN - 1) begin : g_full
      assign bound[k] = LW'((1 << OFS_W) - 1);
    end else begin : g_win
      assign bound[k] = LW'((1 << (k + 2)) - 1);
    end
  end

  assign val = signed'({ofs_i[OFS_W-1], ofs_i});
  assign mag = bound[range_sel_i];

  always_comb begin
    res = val;
    if (val > mag)       res = mag;
    else if (val < -mag) res = -mag;
  end

  assign lim_o = OFS_W'(res);
endmodule

// File: rtl/word_saturator.sv
module word_saturator #(
  parameter int WORD_W   = 12,
  parameter int OFS_W    = 6,
  parameter int WORD_MIN = 96,
  parameter int WORD_MAX = 3903
) (
  input  logic [WORD_W-1:0] base_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int SW = WORD_W + 2;
  localparam logic signed [SW-1:0] LO = SW'(WORD_MIN);
  localparam logic signed [SW-1:0] HI = SW'(WORD_MAX);

  logic signed [SW-1:0] sum, clamped;

  assign sum = signed'({2'b00, base_i}) +
               signed'({{(SW-OFS_W){ofs_i[OFS_W-1]}}, ofs_i});

  always_comb begin
    clamped = sum;
    if (sum < LO)      clamped = LO;
    else if (sum > HI) clamped = HI;
  end

  assign word_o = WORD_W'(clamped);
endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl #(
  parameter int OFS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             auto_mode_i,
  input  logic             strobe_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             ofs_valid_i,
  input  logic [OFS_W-1:0] lim_i,
  output logic [OFS_W-1:0] cand_o,
  output logic [OFS_W-1:0] applied_o
);
  logic [OFS_W-1:0] pend_q, appl_q;
  logic             stb_q, rise, load;

  assign rise   = strobe_i & ~stb_q;
  // a fresh estimate wins over the pending one
  assign cand_o = ofs_valid_i ? ofs_i : pend_q;
  assign load   = enable_i & (auto_mode_i ? ofs_valid_i : rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      pend_q <= '0;
      appl_q <= '0;
    end else begin
      stb_q <= strobe_i;
      if (!enable_i) begin
        pend_q <= '0;
        appl_q <= '0;
      end else begin
        if (ofs_valid_i) pend_q <= ofs_i;
        if (load)        appl_q <= lim_i;
      end
    end
  end

  assign applied_o = appl_q;
endmodule

// File: rtl/freq_trim.sv
module freq_trim #(
  parameter int WORD_W   = 12,
  parameter int OFS_W    = 6,
  parameter int WORD_MIN = 96,
  parameter int WORD_MAX = 3903
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              auto_mode_i,
  input  logic [1:0]        range_sel_i,
  input  logic              strobe_i,
  input  logic [WORD_W-1:0] base_word_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              ofs_valid_i,
  output logic [WORD_W-1:0] word_o
);
  logic [OFS_W-1:0]  cand, lim, applied;
  logic [WORD_W-1:0] sat_word;

  trim_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .auto_mode_i(auto_mode_i),
    .strobe_i   (strobe_i),
    .ofs_i      (ofs_i),
    .ofs_valid_i(ofs_valid_i),
    .lim_i      (lim),
    .cand_o     (cand),
    .applied_o  (applied)
  );

  offset_limiter #(.OFS_W(OFS_W)) u_lim (
    .ofs_i      (cand),
    .range_sel_i(range_sel_i),
    .lim_o      (lim)
  );

  word_saturator #(
    .WORD_W  (WORD_W),
    .OFS_W   (OFS_W),
    .WORD_MIN(WORD_MIN),
    .WORD_MAX(WORD_MAX)
  ) u_sat (
    .base_i(base_word_i),
    .ofs_i (applied),
    .word_o(sat_word)
  );

  assign word_o = enable_i ? sat_word : base_word_i;
endmodule

// File: rtl/freq_trim_chk.sv
module freq_trim_chk #(
  parameter int WORD_W   = 12,
  parameter int WORD_MIN = 96,
  parameter int WORD_MAX = 3903
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              auto_mode_i,
  input logic [1:0]        range_sel_i,
  input logic              strobe_i,
  input logic [WORD_W-1:0] base_word_i,
  input logic              ofs_valid_i,
  input logic [WORD_W-1:0] word_o
);
  logic stb_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_prev <= 1'b0;
    else         stb_prev <= strobe_i;
  end

  assert_disabled_passthru_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> word_o == base_word_i);

  assert_word_in_span_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |-> (int'(word_o) >= WORD_MIN && int'(word_o) <= WORD_MAX));

  assert_narrow_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && auto_mode_i && ofs_valid_i && range_sel_i == 2'd0) |=>
    (!(enable_i && $stable(base_word_i) && int'(base_word_i) >= 200 && int'(base_word_i) <= 3800) ||
     (int'(word_o) + 3 >= int'(base_word_i) && int'(word_o) <= int'(base_word_i) + 3)));

  assert_manual_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !auto_mode_i && !(strobe_i && !stb_prev)) |=>
    (!(enable_i && !auto_mode_i && $stable(base_word_i)) || $stable(word_o)));
endmodule

bind freq_trim freq_trim_chk #(
  .WORD_W  (WORD_W),
  .WORD_MIN(WORD_MIN),
  .WORD_MAX(WORD_MAX)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .auto_mode_i(auto_mode_i),
  .range_sel_i(range_sel_i),
  .strobe_i   (strobe_i),
  .base_word_i(base_word_i),
  .ofs_valid_i(ofs_valid_i),
  .word_o     (word_o)
);

// File: tb/freq_trim_tb.sv
module freq_trim_tb;
  logic        clk = 1'b0;
  logic        rst_ni, enable, auto_mode, strobe, ofs_valid;
  logic [1:0]  range_sel;
  logic [11:0] base_word, word;
  logic [5:0]  ofs;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  freq_trim u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable), .auto_mode_i(auto_mode),
    .range_sel_i(range_sel), .strobe_i(strobe), .base_word_i(base_word),
    .ofs_i(ofs), .ofs_valid_i(ofs_valid), .word_o(word)
  );

  // {range, offset, base, expected}
  localparam logic [31:0] VECS [12] = '{
    {2'd0, 6'd5,  12'd1000, 12'd1003},
    {2'd0, 6'd55, 12'd1000, 12'd997},
    {2'd1, 6'd5,  12'd2000, 12'd2005},
    {2'd1, 6'd44, 12'd2000, 12'd1993},
    {2'd2, 6'd31, 12'd500,  12'd515},
    {2'd2, 6'd48, 12'd500,  12'd485},
    {2'd3, 6'd32, 12'd1000, 12'd968},
    {2'd3, 6'd31, 12'd1000, 12'd1031},
    {2'd3, 6'd31, 12'd3900, 12'd3903},
    {2'd3, 6'd32, 12'd100,  12'd96},
    {2'd3, 6'd0,  12'd4000, 12'd3903},
    {2'd2, 6'd63, 12'd96,   12'd96}
  };

  task automatic chk(input string tag, input logic [11:0] exp);
    n_chk++;
    if (word !== exp) begin
      n_fail++;
      $display("FAIL %s: word_o=%0d expected %0d", tag, word, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_ni = 1'b0; enable = 1'b1; auto_mode = 1'b1; strobe = 1'b0;
    ofs_valid = 1'b0; range_sel = 2'd3; base_word = 12'd1000; ofs = '0;
    repeat (3) @(negedge clk);
    chk("R10 in reset", 12'd1000);
    rst_ni = 1'b1;
    step();
    chk("R10 after reset", 12'd1000);

    // automatic mode vectors: R2 R3 R4
    for (int i = 0; i < 12; i++) begin
      range_sel = VECS[i][31:30];
      ofs       = VECS[i][29:24];
      base_word = VECS[i][23:12];
      ofs_valid = 1'b1;
      step();
      ofs_valid = 1'b0;
      chk($sformatf("R3/R4 vector %0d", i), VECS[i][11:0]);
    end
    repeat (2) step();
    chk("R4 hold without valid", 12'd96);

    // R1 disabled passthrough, no clamp
    enable = 1'b0; base_word = 12'd4095;
    #1 chk("R1 passthrough", 12'd4095);
    step();
    enable = 1'b1; base_word = 12'd1000;
    step();
    chk("R8 cleared after re-enable", 12'd1000);

    // manual mode
    auto_mode = 1'b0; range_sel = 2'd3;
    ofs = 6'd10; ofs_valid = 1'b1;
    step();
    ofs_valid = 1'b0;
    chk("R5 pending only", 12'd1000);
    strobe = 1'b1;
    step();
    chk("R6 strobe edge applies", 12'd1010);
    ofs = 6'd20; ofs_valid = 1'b1;
    step();
    ofs_valid = 1'b0;
    repeat (2) step();
    chk("R7 held strobe", 12'd1010);
    strobe = 1'b0; range_sel = 2'd0;
    step();
    strobe = 1'b1;
    step();
    chk("R9 window at apply", 12'd1003);
    range_sel = 2'd3;
    step();
    chk("R9 later window change", 12'd1003);
    strobe = 1'b0;
    step();
    ofs = 6'd59; ofs_valid = 1'b1; strobe = 1'b1;
    step();
    ofs_valid = 1'b0; strobe = 1'b0;
    chk("R6 same-cycle estimate", 12'd995);

    // R8 pending cleared by disable
    ofs = 6'd12; ofs_valid = 1'b1;
    step();
    ofs_valid = 1'b0; enable = 1'b0;
    step();
    enable = 1'b1;
    step();
    chk("R8 re-enable manual", 12'd1000);
    strobe = 1'b1;
    step();
    strobe = 1'b0;
    chk("R8 pending cleared", 12'd1000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: word_o=%0d expected completion", word);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule